// File: doc/BRIEF.md
# Parity-Protected Control Store Loader

This block is the host-facing loading port of a wide instruction memory. Each stored word has 42 bits: a 40-bit payload and two even-parity bits, one for each 20-bit half of the payload. The host writes words through a small register port that uses one write strobe. It first writes the pointer register, setting the load-enable bit and giving a start location. It then writes each word in two halves. The low half holds payload bits 31:0 and is only staged. The high half holds payload bits 39:32 in bits 7:0 and the two parity bits in bits 9:8. Writing the high half stores the whole word and advances the pointer by one, modulo the store depth.

The parity bits are supplied by the host and stored as given. On the read side, a consumer issues single-word fetches over a valid/ready handshake. When parity checking is enabled in the mode register, each response is checked against its stored parity. A mismatch drives a per-response error pin and sets a sticky error flag, which the host clears by writing a 1. Reading the pointer back shows whether a load ran past the last location, because the address field then reads zero while the load-enable bit is still set.

Fetch back-pressure works as follows. `fetch_ready` is low in any cycle where a high-half write stores a word, because the single-port array is busy. A fetch is taken only on a cycle where `fetch_valid` and `fetch_ready` are both high. A taken fetch is answered exactly one cycle later on `rsp_valid`, and the response has no ready signal of its own.

Top module: `cstore_wport`

## Requirements
- R1: After reset, all readable registers read zero: pointer at offset 0x00, mode at offset 0x0C and status at offset 0x10. `rsp_valid` and `perr_flag` are low, and `fetch_ready` is high.
- R2: A write to offset 0x00 sets the load-enable state from bit 31 and the pointer from bits AW-1:0. Reading offset 0x00 returns the load-enable state in bit 31, the pointer in bits AW-1:0, and zeros elsewhere. Writing all zeros leaves load mode.
- R3: A write to offset 0x04 in load mode only stages 32 bits. It leaves the pointer and the store contents unchanged.
- R4: A write to offset 0x08 in load mode stores word {wdata[9:0], staged low half} at the pointer and increments the pointer. Word bits 39:0 are the payload, bit 40 is the parity of the low payload field and bit 41 is the parity of the high payload field.
- R5: A store at the last location (DEPTH-1) wraps the pointer to 0. A readback then returns bit 31 set with the address field zero.
- R6: Writes to offsets 0x04 and 0x08 outside load mode are ignored. They change neither the store, nor the pointer, nor the staged low half.
- R7: A fetch taken with `fetch_valid` and `fetch_ready` both high returns the stored word on `rsp_word`, with `rsp_valid` high, in the next cycle only. `fetch_ready` is low in every cycle that stores a word.
- R8: With mode bit 28 set when the fetch is taken, `rsp_perr` is high with the response if and only if bit 40 differs from the XOR of payload bits 19:0 or bit 41 differs from the XOR of payload bits 39:20. With bit 28 clear, `rsp_perr` stays low.
- R9: Status bit 0 and `perr_flag` become set after a response with `rsp_perr` high. They stay set until a write of 1 to bit 0 of offset 0x10, and a parity error in the same cycle as that clear takes precedence.
- R10: The mode register keeps only bit 28. All other bits of offset 0x0C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte offset for writes and reads |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data for the register at `host_addr` (combinational) |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request accepted this cycle |
| fetch_addr | input | AW (10) | Store location to fetch |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_word | output | 42 | Fetched word: parity bits 41:40, payload bits 39:0 |
| rsp_perr | output | 1 | Parity mismatch on the current response |
| perr_flag | output | 1 | Sticky parity error flag |

## Verification
The bench stages a low half and then rewrites it without a commit. A design that stored the word on the low-half write would return the newer data in place of the old word. It also issues data writes with load mode off. This would expose a design that committed them, advanced the pointer, or overwrote the staged half, because a later single high-half commit would then carry the wrong low bits. The pointer is driven to the last location and across the wrap boundary, both by hand and from random bases, to catch a missed wrap or a lost load-enable bit on readback. Parity is corrupted separately in each field and checked with checking enabled and disabled. A fetch collides with a commit, and a clear collides with a new error, so a swapped field, a missing back-pressure or a clear-priority mistake each produces a visible mismatch.

// File: rtl/cstore_pkg.sv
package cstore_pkg;
  localparam int unsigned HOST_AW   = 8;
  localparam int unsigned HOST_DW   = 32;
  localparam int unsigned PAY_W     = 40;
  localparam int unsigned FIELD_W   = 20;
  localparam int unsigned NFIELD    = PAY_W / FIELD_W;
  localparam int unsigned WORD_W    = PAY_W + NFIELD;
  localparam int unsigned HI_USED   = WORD_W - HOST_DW;
  localparam int unsigned PROG_BIT  = 31;
  localparam int unsigned CHKEN_BIT = 28;

  localparam logic [HOST_AW-1:0] OFS_PTR  = 8'h00;
  localparam logic [HOST_AW-1:0] OFS_LO   = 8'h04;
  localparam logic [HOST_AW-1:0] OFS_HI   = 8'h08;
  localparam logic [HOST_AW-1:0] OFS_MODE = 8'h0C;
  localparam logic [HOST_AW-1:0] OFS_STAT = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PTR, SEL_LO, SEL_HI, SEL_MODE, SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [HOST_AW-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_PTR:  s = SEL_PTR;
      OFS_LO:   s = SEL_LO;
      OFS_HI:   s = SEL_HI;
      OFS_MODE: s = SEL_MODE;
      OFS_STAT: s = SEL_STAT;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cstore_regs.sv
module cstore_regs
  import cstore_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic               perr_flag,
  output logic               prog,
  output logic [AW-1:0]      wptr,
  output logic               commit,
  output logic [WORD_W-1:0]  commit_word,
  output logic               chk_en,
  output logic               clr_err,
  output logic [HOST_DW-1:0] host_rdata
);
  reg_sel_e           wsel;
  reg_sel_e           rsel;
  logic [HOST_DW-1:0] lo_q;

  assign wsel        = host_wr ? decode_ofs(host_addr) : SEL_NONE;
  assign rsel        = decode_ofs(host_addr);
  assign commit      = (wsel == SEL_HI) && prog;
  assign commit_word = {host_wdata[HI_USED-1:0], lo_q};
  assign clr_err     = (wsel == SEL_STAT) && host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog   <= 1'b0;
      wptr   <= '0;
      lo_q   <= '0;
      chk_en <= 1'b0;
    end else begin
      if (wsel == SEL_PTR) begin
        prog <= host_wdata[PROG_BIT];
        wptr <= host_wdata[AW-1:0];
      end else if (commit) begin
        wptr <= wptr + AW'(1);
      end
      if ((wsel == SEL_LO) && prog) lo_q <= host_wdata;
      if (wsel == SEL_MODE) chk_en <= host_wdata[CHKEN_BIT];
    end
  end

  always_comb begin
    host_rdata = '0;
    case (rsel)
      SEL_PTR: begin
        host_rdata[PROG_BIT] = prog;
        host_rdata[AW-1:0]   = wptr;
      end
      SEL_MODE: host_rdata[CHKEN_BIT] = chk_en;
      SEL_STAT: host_rdata[0]         = perr_flag;
      default:  host_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/cstore_mem.sv
module cstore_mem
  import cstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_fire,
  input  logic [AW-1:0]     rd_addr,
  input  logic              chk_en_in,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_chk
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)   mem[wr_addr] <= wr_word;
    if (rd_fire) rsp_word     <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_chk   <= 1'b0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_chk <= chk_en_in;
    end
  end
endmodule

// File: rtl/cstore_parity.sv
module cstore_parity
  import cstore_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_word,
  input  logic              rsp_chk,
  input  logic              clr_err,
  output logic              rsp_perr,
  output logic              perr_flag
);
  logic [NFIELD-1:0] mism;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign mism[g] = rsp_word[PAY_W+g] != (^rsp_word[g*FIELD_W +: FIELD_W]);
  end

  assign rsp_perr = rsp_valid && rsp_chk && (|mism);

  always_ff @(posedge clk) begin
    if (!rst_n)        perr_flag <= 1'b0;
    else if (rsp_perr) perr_flag <= 1'b1;
    else if (clr_err)  perr_flag <= 1'b0;
  end
endmodule

// File: rtl/cstore_wport.sv
module cstore_wport
  import cstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [AW-1:0]      fetch_addr,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_word,
  output logic               rsp_perr,
  output logic               perr_flag
);
  logic              prog;
  logic [AW-1:0]     wptr;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  logic              chk_en;
  logic              clr_err;
  logic              rsp_chk;

  cstore_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .perr_flag(perr_flag), .prog(prog), .wptr(wptr),
    .commit(commit), .commit_word(commit_word), .chk_en(chk_en),
    .clr_err(clr_err), .host_rdata(host_rdata)
  );

  assign fetch_ready = !commit;

  cstore_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_addr(wptr),
    .wr_word(commit_word), .rd_fire(fetch_valid && fetch_ready),
    .rd_addr(fetch_addr), .chk_en_in(chk_en), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .rsp_chk(rsp_chk)
  );

  cstore_parity u_par (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .rsp_chk(rsp_chk), .clr_err(clr_err), .rsp_perr(rsp_perr),
    .perr_flag(perr_flag)
  );
endmodule

// File: rtl/cstore_wport_chk.sv
module cstore_wport_chk
  import cstore_pkg::*;
#(
  parameter int AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr,
  input logic [HOST_AW-1:0] host_addr,
  input logic [HOST_DW-1:0] host_wdata,
  input logic               fetch_valid,
  input logic               fetch_ready,
  input logic               rsp_valid,
  input logic               rsp_perr,
  input logic               perr_flag,
  input logic               prog,
  input logic [AW-1:0]      wptr
);
  logic hi_wr, data_wr;
  assign hi_wr   = host_wr && (host_addr == OFS_HI);
  assign data_wr = host_wr && ((host_addr == OFS_HI) || (host_addr == OFS_LO));

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_PTR) |=> (prog == $past(host_wdata[PROG_BIT])));

  p_addr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && prog) |=> (wptr == $past(wptr) + AW'(1)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && prog && (&wptr)) |=> (wptr == '0 && prog));

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !prog) |=> ($stable(wptr) && !prog));

  p_no_fetch_on_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && prog) |-> !fetch_ready);

  p_rsp_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> rsp_valid);

  p_rsp_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_ready) |=> !rsp_valid);

  p_perr_with_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |-> rsp_valid);

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |=> perr_flag);

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !(host_wr && host_addr == OFS_STAT && host_wdata[0])) |=> perr_flag);
endmodule

bind cstore_wport cstore_wport_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .rsp_valid(rsp_valid), .rsp_perr(rsp_perr), .perr_flag(perr_flag),
  .prog(prog), .wptr(wptr)
);

// File: tb/tb_cstore_wport.sv
module tb_cstore_wport;
  import cstore_pkg::*;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_wr = 1'b0;
  logic [HOST_AW-1:0] host_addr = '0;
  logic [HOST_DW-1:0] host_wdata = '0;
  logic [HOST_DW-1:0] host_rdata;
  logic               fetch_valid = 1'b0;
  logic               fetch_ready;
  logic [AW-1:0]      fetch_addr = '0;
  logic               rsp_valid;
  logic [WORD_W-1:0]  rsp_word;
  logic               rsp_perr;
  logic               perr_flag;

  always #5 clk = ~clk;

  cstore_wport #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .rsp_perr(rsp_perr), .perr_flag(perr_flag)
  );

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] model [DEPTH];
  logic        prog_m = 1'b0;
  int          ptr_m  = 0;
  logic [31:0] lo_m   = '0;
  logic        en_m   = 1'b0;

  function automatic logic [1:0] good_par(input logic [39:0] p);
    return {^p[39:20], ^p[19:0]};
  endfunction

  function automatic logic exp_perr(input logic [41:0] w, input logic en);
    return en && (w[41:40] != good_par(w[39:0]));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    case (a)
      OFS_PTR: begin prog_m = d[31]; ptr_m = int'(d[AW-1:0]); end
      OFS_LO:  if (prog_m) lo_m = d;
      OFS_HI:  if (prog_m) begin
                 model[ptr_m] = {d[9:0], lo_m};
                 ptr_m = (ptr_m + 1) % DEPTH;
               end
      OFS_MODE: en_m = d[28];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic fetch(input int a, output logic v, output logic [41:0] w, output logic pe);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_valid = 1'b0;
    v = rsp_valid; w = rsp_word; pe = rsp_perr;
  endtask

  task automatic put_word(input logic [39:0] p, input logic [1:0] flip);
    wr(OFS_LO, p[31:0]);
    wr(OFS_HI, {22'b0, good_par(p) ^ flip, p[7+32:32]});
  endtask

  task automatic fetch_chk(input string tag, input int a);
    logic v; logic [41:0] w; logic pe;
    fetch(a, v, w, pe);
    check({tag, " rsp_valid"}, 64'(v), 64'(1));
    check({tag, " rsp_word"}, 64'(w), 64'(model[a]));
    check({tag, " rsp_perr"}, 64'(pe), 64'(exp_perr(model[a], en_m)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [39:0] pa, pb, pc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(OFS_PTR, r);  check("R1 ptr", 64'(r), 64'(0));
    rd(OFS_MODE, r); check("R1 mode", 64'(r), 64'(0));
    rd(OFS_STAT, r); check("R1 stat", 64'(r), 64'(0));
    check("R1 rsp_valid", 64'(rsp_valid), 64'(0));
    check("R1 perr_flag", 64'(perr_flag), 64'(0));
    check("R1 fetch_ready", 64'(fetch_ready), 64'(1));

    // R2 / R4 basic load
    wr(OFS_PTR, 32'h8000_0000);
    rd(OFS_PTR, r); check("R2 enter", 64'(r), 64'h8000_0000);
    put_word(40'h12_3456_789A, 2'b00);
    wr(OFS_PTR, 32'h8000_0005);
    rd(OFS_PTR, r); check("R2 start addr", 64'(r), 64'h8000_0005);
    pa = 40'hA5_0F0F_1234;
    put_word(pa, 2'b00);
    rd(OFS_PTR, r); check("R4 incr", 64'(r), 64'h8000_0006);
    fetch_chk("R4 word5", 5);

    // R3 staging only
    pb = 40'h3C_DEAD_BEEF;
    put_word(pb, 2'b00);
    wr(OFS_PTR, 32'h8000_0006);
    wr(OFS_LO, 32'h0BAD_F00D);
    rd(OFS_PTR, r); check("R3 ptr unchanged", 64'(r), 64'h8000_0006);
    fetch_chk("R3 store unchanged", 6);
    wr(OFS_HI, {22'b0, 2'b11, 8'h77});
    fetch_chk("R4 staged low used", 6);

    // R6 ignored outside load mode
    wr(OFS_PTR, 32'h0000_0000);
    rd(OFS_PTR, r); check("R2 leave", 64'(r), 64'(0));
    wr(OFS_LO, 32'hFFFF_FFFF);
    wr(OFS_HI, 32'h0000_03FF);
    rd(OFS_PTR, r); check("R6 ptr", 64'(r), 64'(0));
    fetch_chk("R6 store", 0);
    wr(OFS_PTR, 32'h8000_0000);
    wr(OFS_HI, 32'h0000_0001);
    fetch_chk("R6 staged kept", 0);

    // R5 wrap
    wr(OFS_PTR, 32'h8000_0000 | (DEPTH - 1));
    pc = 40'hFE_CAFE_0001;
    put_word(pc, 2'b00);
    rd(OFS_PTR, r); check("R5 wrap readback", 64'(r), 64'h8000_0000);
    fetch_chk("R5 last word", DEPTH - 1);

    // R10 mode register
    wr(OFS_MODE, 32'hFFFF_FFFF);
    rd(OFS_MODE, r); check("R10 mode bits", 64'(r), 64'h1000_0000);

    // R8 / R9 parity
    wr(OFS_PTR, 32'h8000_0020);
    put_word(40'h11_2233_4455, 2'b01);
    put_word(40'h66_7788_99AA, 2'b10);
    put_word(40'h0F_0000_FFFF, 2'b00);
    fetch_chk("R8 low field bad", 32'h20);
    rd(OFS_STAT, r); check("R9 sticky set", 64'(r), 64'(1));
    check("R9 perr_flag pin", 64'(perr_flag), 64'(1));
    fetch_chk("R8 good word", 32'h22);
    rd(OFS_STAT, r); check("R9 sticky holds", 64'(r), 64'(1));
    wr(OFS_STAT, 32'h1);
    rd(OFS_STAT, r); check("R9 cleared", 64'(r), 64'(0));
    fetch_chk("R8 high field bad", 32'h21);
    // R9 set wins over clear in the same cycle
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = AW'(32'h20);
    @(negedge clk);
    fetch_valid = 1'b0;
    host_wr = 1'b1; host_addr = OFS_STAT; host_wdata = 32'h1;
    @(negedge clk);
    host_wr = 1'b0;
    rd(OFS_STAT, r); check("R9 set beats clear", 64'(r), 64'(1));
    wr(OFS_STAT, 32'h1);
    wr(OFS_MODE, 32'h0);
    fetch_chk("R8 disabled no perr", 32'h20);
    rd(OFS_STAT, r); check("R8 disabled no sticky", 64'(r), 64'(0));

    // R7 back-pressure during commit
    wr(OFS_PTR, 32'h8000_0030);
    wr(OFS_LO, 32'h5555_AAAA);
    @(negedge clk);
    host_wr = 1'b1; host_addr = OFS_HI; host_wdata = 32'h0000_0042;
    fetch_valid = 1'b1; fetch_addr = AW'(5);
    #1 check("R7 ready low on commit", 64'(fetch_ready), 64'(0));
    @(negedge clk);
    host_wr = 1'b0; fetch_valid = 1'b0;
    model_wr(OFS_HI, 32'h0000_0042);
    check("R7 no response", 64'(rsp_valid), 64'(0));
    fetch_chk("R7 committed word", 32'h30);

    // random loads with parity enabled
    wr(OFS_MODE, 32'h1000_0000);
    for (int it = 0; it < 250; it++) begin
      int base;
      base = int'($urandom() % DEPTH);
      wr(OFS_PTR, 32'h8000_0000 | 32'(base));
      for (int k = 0; k < 4; k++) begin
        logic [39:0] p;
        logic [1:0] fl;
        p  = {8'($urandom()), 32'($urandom())};
        fl = ($urandom() % 4 == 0) ? 2'(1 << ($urandom() % 2)) : 2'b00;
        put_word(p, fl);
      end
      rd(OFS_PTR, r);
      check("R5 R4 random ptr", 64'(r), 64'(32'h8000_0000 | 32'((base + 4) % DEPTH)));
      for (int k = 0; k < 4; k++) fetch_chk("R8 R7 random fetch", (base + k) % DEPTH);
      wr(OFS_STAT, 32'h1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule